// File: doc/BRIEF.md
# Termination Enable Gating Controller

This block belongs to the memory-controller side of a DDR2-style interface. It decides when the on-die termination control pin of the memory may go high. It watches every extended mode register write and keeps the last termination-strength code written. It also tracks the operating mode the device is in. A termination request from the scheduler reaches the pin only when three conditions hold: termination is enabled, the settling interval after the enabling write has passed, and the device is in a mode where termination is legal.

A request that arrives at a forbidden time does not reach the pin. The block suppresses it and raises a one-cycle violation pulse. It raises the same pulse if the device is put into self-refresh entry while the pin is still high. The block also translates the programmed code into a strength value, so the rest of the controller does not have to decode mode-register bits.

The pin and the violation flag come from registers: the request and the mode seen on one clock edge affect the outputs right after that edge.

Top module: `term_gate_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `term_pin_o` and `viol_o` are low after that edge and `strength_o` is 0 (off).
- R2: The strength code is taken from mode-register value bits 6 (high) and 2 (low). All other bits are ignored. After the write edge, `strength_o` shows the strength: code 00 gives 0 (off), 01 gives 2 (75 ohm), 10 gives 3 (150 ohm), and 11 gives 1 (50 ohm).
- R3: Suppose a write with a nonzero code is sampled at edge k. Then `term_pin_o` is low after edges k through k+8. If the request is held in an allowed mode, the pin is high after edge k+9.
- R4: Only these `op_mode_i` values allow the pin: 1 (active), 2 (active power-down, fast exit), 3 (active power-down, slow exit) and 4 (precharge power-down). With any other value (0 = initialization, 5 = self-refresh entry, 6, 7) the pin is low after the edge.
- R5: If `op_mode_i` is 5 while `term_pin_o` is high, `viol_o` is high after that edge.
- R6: A request made while termination is enabled, but during the settling window or in a forbidden mode, is suppressed. It makes `viol_o` high for the cycle after that edge. A request made during the write cycle of an enabling write counts as inside the window.
- R7: A write with code 00 forces the pin low after its edge. While termination is disabled, requests give neither pin nor violation.
- R8: Each new write with a nonzero code restarts the settling window, even when the pin is already high.
- R9: With the request low, the pin is low after the edge, and no violation is raised for an allowed mode.
- R10: After reset and before any enabling write, requests in an allowed mode leave the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_wr_i | input | 1 | One-cycle pulse marking an extended mode register write |
| mr_val_i | input | EMR_W (16) | Value written to the extended mode register |
| op_mode_i | input | 3 | Current device operating mode |
| term_req_i | input | 1 | Termination request from the scheduler |
| term_pin_o | output | 1 | Gated termination control pin |
| strength_o | output | 2 | Decoded termination strength (0 off, 1 50 ohm, 2 75 ohm, 3 150 ohm) |
| viol_o | output | 1 | One-cycle protocol violation pulse |

## Verification
The bench holds a request high through an enabling write. It checks every cycle of the window: a counter that is one short would raise the pin on edge k+8, and one that forgets the write cycle itself would miss the first violation. A second enabling write while the pin is high checks the restart; a design that only counts after the first write would keep the pin up. Other checks cover a disabling write with the request still high, which must clear the pin silently, and a move into self-refresh entry straight from a high pin, which must pulse the violation flag. The code decode is checked with every other bit of the register set, so a design that reads the wrong or adjacent bits shows a wrong strength.

// File: rtl/term_gate_pkg.sv
package term_gate_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        OPM_INIT        = 3'd0,
        OPM_ACTIVE      = 3'd1,
        OPM_ACT_PD_FAST = 3'd2,
        OPM_ACT_PD_SLOW = 3'd3,
        OPM_PRE_PD      = 3'd4,
        OPM_SR_ENTRY    = 3'd5
    } op_mode_t;

    typedef enum logic [1:0] {
        TS_OFF = 2'd0,
        TS_50  = 2'd1,
        TS_75  = 2'd2,
        TS_150 = 2'd3
    } term_strength_t;

    typedef logic [1:0] rtt_code_t;

    // Per-cycle view of the gating conditions
    typedef struct packed {
        logic enabled;
        logic settling;
        logic mode_ok;
        logic sr_entry;
    } gate_view_t;

    function automatic term_strength_t rtt_decode(input rtt_code_t code);
        case (code)
            2'b01:   return TS_75;
            2'b10:   return TS_150;
            2'b11:   return TS_50;
            default: return TS_OFF;
        endcase
    endfunction

endpackage

// File: rtl/term_code_capture.sv
module term_code_capture
    import term_gate_pkg::*;
#(
    parameter int EMR_W      = 16,
    parameter int RTT_LO_BIT = 2,
    parameter int RTT_HI_BIT = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mr_wr_i,
    input  logic [EMR_W-1:0] mr_val_i,
    output rtt_code_t        new_code_o,
    output rtt_code_t        code_q_o
);

    rtt_code_t code_q;

    assign new_code_o = {mr_val_i[RTT_HI_BIT], mr_val_i[RTT_LO_BIT]};

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= 2'b00;
        end else if (mr_wr_i) begin
            code_q <= new_code_o;
        end
    end

    assign code_q_o = code_q;

endmodule

// File: rtl/term_settle_timer.sv
module term_settle_timer #(
    parameter int SETTLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic settled_o
);

    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign settled_o = (cnt_q == LIMIT);

endmodule

// File: rtl/term_mode_check.sv
module term_mode_check
    import term_gate_pkg::*;
(
    input  logic [MODE_W-1:0] op_mode_i,
    output logic              mode_ok_o,
    output logic              sr_entry_o
);

    always_comb begin
        mode_ok_o = 1'b0;
        case (op_mode_i)
            OPM_ACTIVE, OPM_ACT_PD_FAST,
            OPM_ACT_PD_SLOW, OPM_PRE_PD: mode_ok_o = 1'b1;
            default:                     mode_ok_o = 1'b0;
        endcase
        sr_entry_o = (op_mode_i == OPM_SR_ENTRY);
    end

endmodule

// File: rtl/term_gate_ctrl.sv
module term_gate_ctrl
    import term_gate_pkg::*;
#(
    parameter int EMR_W         = 16,
    parameter int RTT_LO_BIT    = 2,
    parameter int RTT_HI_BIT    = 6,
    parameter int SETTLE_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mr_wr_i,
    input  logic [EMR_W-1:0] mr_val_i,
    input  logic [2:0]       op_mode_i,
    input  logic             term_req_i,
    output logic             term_pin_o,
    output logic [1:0]       strength_o,
    output logic             viol_o
);

    rtt_code_t  new_code, code_q;
    logic       settled, mode_ok, sr_entry;
    gate_view_t gv;
    logic       pin_q, viol_q, pin_d, viol_d;

    term_code_capture #(
        .EMR_W      (EMR_W),
        .RTT_LO_BIT (RTT_LO_BIT),
        .RTT_HI_BIT (RTT_HI_BIT)
    ) u_capture (
        .clk        (clk),
        .rst        (rst),
        .mr_wr_i    (mr_wr_i),
        .mr_val_i   (mr_val_i),
        .new_code_o (new_code),
        .code_q_o   (code_q)
    );

    term_settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (mr_wr_i),
        .settled_o (settled)
    );

    term_mode_check u_mode (
        .op_mode_i  (op_mode_i),
        .mode_ok_o  (mode_ok),
        .sr_entry_o (sr_entry)
    );

    // A write in flight decides the state for this cycle
    always_comb begin
        gv.enabled  = mr_wr_i ? (new_code != 2'b00) : (code_q != 2'b00);
        gv.settling = mr_wr_i ? gv.enabled : (gv.enabled && !settled);
        gv.mode_ok  = mode_ok;
        gv.sr_entry = sr_entry;

        pin_d  = term_req_i && gv.enabled && !gv.settling && gv.mode_ok;
        viol_d = (term_req_i && gv.enabled && (gv.settling || !gv.mode_ok))
               || (gv.sr_entry && pin_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q  <= 1'b0;
            viol_q <= 1'b0;
        end else begin
            pin_q  <= pin_d;
            viol_q <= viol_d;
        end
    end

    assign term_pin_o = pin_q;
    assign viol_o     = viol_q;
    assign strength_o = rtt_decode(code_q);

endmodule

// File: rtl/term_gate_checker.sv
module term_gate_checker #(
    parameter int EMR_W         = 16,
    parameter int RTT_LO_BIT    = 2,
    parameter int RTT_HI_BIT    = 6,
    parameter int SETTLE_CYCLES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mr_wr_i,
    input logic [EMR_W-1:0] mr_val_i,
    input logic [2:0]       op_mode_i,
    input logic             term_req_i,
    input logic             term_pin_o,
    input logic [1:0]       strength_o,
    input logic             viol_o
);

    localparam int SW = $clog2(SETTLE_CYCLES + 2);
    localparam logic [SW-1:0] SAT = SW'(SETTLE_CYCLES + 1);

    // Edges since the last mode-register write, saturating
    logic [SW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (rst || mr_wr_i) since_q <= '0;
        else if (since_q != SAT) since_q <= since_q + 1'b1;
    end

    logic allowed_mode;
    assign allowed_mode = (op_mode_i >= 3'd1) && (op_mode_i <= 3'd4);

    logic [1:0] exp_str;
    assign exp_str = {mr_val_i[RTT_HI_BIT], mr_val_i[RTT_LO_BIT]} == 2'b01 ? 2'd2 :
                     {mr_val_i[RTT_HI_BIT], mr_val_i[RTT_LO_BIT]} == 2'b10 ? 2'd3 :
                     {mr_val_i[RTT_HI_BIT], mr_val_i[RTT_LO_BIT]} == 2'b11 ? 2'd1 : 2'd0;

    p_strength_r2: assert property (@(posedge clk) disable iff (rst)
        mr_wr_i |=> strength_o == $past(exp_str));

    p_settle_low_r3: assert property (@(posedge clk) disable iff (rst)
        term_pin_o |-> (since_q == SAT));

    p_mode_gate_r4: assert property (@(posedge clk) disable iff (rst)
        !allowed_mode |=> !term_pin_o);

    p_sr_viol_r5: assert property (@(posedge clk) disable iff (rst)
        (op_mode_i == 3'd5 && term_pin_o) |=> viol_o);

    p_disable_low_r7: assert property (@(posedge clk) disable iff (rst)
        (mr_wr_i && !mr_val_i[RTT_HI_BIT] && !mr_val_i[RTT_LO_BIT]) |=> !term_pin_o);

    p_req_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !term_req_i |=> !term_pin_o);

endmodule

bind term_gate_ctrl term_gate_checker #(
    .EMR_W         (EMR_W),
    .RTT_LO_BIT    (RTT_LO_BIT),
    .RTT_HI_BIT    (RTT_HI_BIT),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mr_wr_i    (mr_wr_i),
    .mr_val_i   (mr_val_i),
    .op_mode_i  (op_mode_i),
    .term_req_i (term_req_i),
    .term_pin_o (term_pin_o),
    .strength_o (strength_o),
    .viol_o     (viol_o)
);

// File: tb/term_gate_ctrl_bench.sv
module term_gate_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mr_wr = 1'b0;
    logic [15:0] mr_val = 16'h0000;
    logic [2:0]  op_mode = 3'd0;
    logic        req = 1'b0;
    logic        pin, viol;
    logic [1:0]  str;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    term_gate_ctrl u_term_gate_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mr_wr_i    (mr_wr),
        .mr_val_i   (mr_val),
        .op_mode_i  (op_mode),
        .term_req_i (req),
        .term_pin_o (pin),
        .strength_o (str),
        .viol_o     (viol)
    );

    // Rows: {mode[2:0], req, exp_pin, exp_viol, exp_str[1:0]}; code 11 settled
    localparam logic [7:0] VEC [12] = '{
        {3'd1, 1'b1, 1'b1, 1'b0, 2'd1},
        {3'd2, 1'b1, 1'b1, 1'b0, 2'd1},
        {3'd3, 1'b1, 1'b1, 1'b0, 2'd1},
        {3'd4, 1'b0, 1'b0, 1'b0, 2'd1},
        {3'd4, 1'b1, 1'b1, 1'b0, 2'd1},
        {3'd5, 1'b0, 1'b0, 1'b1, 2'd1},
        {3'd0, 1'b1, 1'b0, 1'b1, 2'd1},
        {3'd6, 1'b1, 1'b0, 1'b1, 2'd1},
        {3'd7, 1'b0, 1'b0, 1'b0, 2'd1},
        {3'd1, 1'b1, 1'b1, 1'b0, 2'd1},
        {3'd1, 1'b0, 1'b0, 1'b0, 2'd1},
        {3'd5, 1'b0, 1'b0, 1'b0, 2'd1}
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic emr_write(input logic [1:0] code);
        mr_val    = 16'hFFBB;
        mr_val[6] = code[1];
        mr_val[2] = code[0];
        mr_wr     = 1'b1;
        tick();
        mr_wr     = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int exp_map [4];
        exp_map = '{0, 2, 3, 1};

        // R1: reset state
        tick();
        tick();
        chk("R1", "pin", pin, 0);
        chk("R1", "viol", viol, 0);
        chk("R1", "strength", str, 0);
        rst = 1'b0;

        // R10: requests before any enabling write
        op_mode = 3'd1;
        req     = 1'b1;
        for (int i = 0; i < 12; i++) begin
            tick();
            chk("R10", "pin before enable", pin, 0);
            chk("R7", "viol while disabled", viol, 0);
        end

        // R2: decode with every other bit set
        req = 1'b0;
        for (int c = 1; c <= 4; c++) begin
            emr_write(2'(c % 4));
            chk("R2", "strength", str, exp_map[c % 4]);
        end

        // R3, R6: settling window with request held
        req = 1'b1;
        emr_write(2'b01);
        chk("R6", "viol on write cycle", viol, 1);
        chk("R3", "pin on write edge", pin, 0);
        for (int i = 1; i <= 8; i++) begin
            tick();
            chk("R3", "pin in window", pin, 0);
            chk("R6", "viol in window", viol, 1);
        end
        tick();
        chk("R3", "pin after window", pin, 1);
        chk("R6", "viol after window", viol, 0);

        // R8: rewrite restarts window
        emr_write(2'b10);
        chk("R8", "pin drops on rewrite", pin, 0);
        chk("R2", "strength 150", str, 3);
        for (int i = 1; i <= 8; i++) begin
            tick();
            chk("R8", "pin in restarted window", pin, 0);
        end
        tick();
        chk("R8", "pin after restart", pin, 1);

        // R7: disabling write with request high
        emr_write(2'b00);
        chk("R7", "pin after disable", pin, 0);
        chk("R7", "viol after disable", viol, 0);
        chk("R2", "strength off", str, 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R7", "pin while disabled", pin, 0);
            chk("R7", "viol while disabled", viol, 0);
        end

        // Table walk with code 11 settled
        req = 1'b0;
        emr_write(2'b11);
        repeat (9) tick();
        chk("R9", "pin idle after settle", pin, 0);
        for (int r = 0; r < 12; r++) begin
            string tag;
            op_mode = VEC[r][7:5];
            req     = VEC[r][4];
            if (op_mode == 3'd5)                        tag = "R5";
            else if (op_mode == 3'd0 || op_mode > 3'd4) tag = "R4";
            else if (!req)                              tag = "R9";
            else                                        tag = "R4";
            tick();
            chk(tag, "pin", pin, VEC[r][3]);
            chk(tag, "viol", viol, VEC[r][2]);
            chk("R2", "strength 50", str, VEC[r][1:0]);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule